// File: doc/BRIEF.md
# Memory Bank Occupancy Controller

This block models the timing of a single memory bank. Requests enter a small queue. Each one carries a tag, a two-bit command and the cycle in which it was accepted. When the bank is free and the queue holds an entry, the oldest entry starts. Starting an entry marks the bank busy, counts one access and adds that entry's queueing delay to a running total. The bank then stays occupied for a fixed latency.

What happens when an occupancy ends depends on the command. A read or an exclusive read produces a one-cycle reply pulse toward the high-priority bus arbiter. A writeback gives back its buffer slot in its first busy cycle but still holds the bank for the whole latency. A sharing writeback only holds the bank, and it signals its release when it finishes. After an occupancy ends, the next queued entry starts at once. If the queue is empty, the busy flag drops.

Top module: `bank_occupancy_ctrl`

## Requirements
- R1: After reset, busy, every pulse output, the access counter and the wait total are 0, and req_ready is 1.
- R2: The queue accepts a request in a cycle where req_valid and req_ready are both 1. req_ready is 0 while DEPTH (8) entries are held. A request offered while req_ready is 0 is dropped and never completes. Command codes are 0 for read, 1 for exclusive read, 2 for writeback and 3 for sharing writeback.
- R3: Entries start strictly in acceptance order. Each start increments access_count by exactly one.
- R4: At each start, wait_total grows by the number of clock edges between acceptance and start. The minimum is 1, for an entry accepted while the bank is idle.
- R5: The bank stays busy for exactly LAT (default 20) consecutive cycles per entry. The completion cycle is the last of these cycles.
- R6: For commands 0 and 1, reply_valid pulses in the completion cycle with the entry's tag. reply_excl is 1 only for command 1.
- R7: For command 2, wb_free_valid pulses with the tag in the first busy cycle. The bank still stays busy for LAT cycles, and no reply is produced.
- R8: For command 3, swb_done_valid pulses with the tag in the completion cycle only.
- R9: If the queue is not empty in a completion cycle, the next entry is busy in the following cycle with no gap. Otherwise busy is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_cmd | input | 2 | Command code |
| req_tag | input | TAG_W | Request tag |
| req_ready | output | 1 | Queue has room |
| busy | output | 1 | Bank occupied |
| reply_valid | output | 1 | Read completion toward the high-priority arbiter |
| reply_excl | output | 1 | Completion is an exclusive read |
| reply_tag | output | TAG_W | Tag of the completing read |
| wb_free_valid | output | 1 | Writeback buffer slot released |
| wb_free_tag | output | TAG_W | Tag of the released writeback |
| swb_done_valid | output | 1 | Sharing writeback finished |
| swb_done_tag | output | TAG_W | Tag of the finished sharing writeback |
| access_count | output | CNT_W | Number of starts |
| wait_total | output | SUM_W | Sum of queueing delays |

## Verification
The hardest case to reach is a completion that falls in the same cycle as a push while the queue is full or nearly full. That case exercises back-to-back starts, the refusal of a push, and large wait values all together. The bench reaches it with bursts of more requests than the queue holds, offered every cycle with mixed commands. It then adds random traffic with idle gaps, so that single-entry starts with a wait of 1 and the transition to idle are also covered. A behavioural model built from queues and integers predicts every output, and the two are compared on every cycle.

// File: rtl/bank_occupancy_ctrl.sv
module bank_occupancy_ctrl #(
  parameter int LAT   = 20,
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int TS_W  = 16,
  parameter int CNT_W = 32,
  parameter int SUM_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_cmd,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_ready,
  output logic             busy,
  output logic             reply_valid,
  output logic             reply_excl,
  output logic [TAG_W-1:0] reply_tag,
  output logic             wb_free_valid,
  output logic [TAG_W-1:0] wb_free_tag,
  output logic             swb_done_valid,
  output logic [TAG_W-1:0] swb_done_tag,
  output logic [CNT_W-1:0] access_count,
  output logic [SUM_W-1:0] wait_total
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FIL_W = $clog2(DEPTH + 1);
  localparam int TMR_W = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [1:0] CMD_WB  = 2'd2;
  localparam logic [1:0] CMD_SWB = 2'd3;

  logic [TAG_W-1:0] q_tag [DEPTH];
  logic [1:0]       q_cmd [DEPTH];
  logic [TS_W-1:0]  q_ts  [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [FIL_W-1:0] fill;
  logic [TS_W-1:0]  now;
  logic [TMR_W-1:0] timer;
  logic [1:0]       cur_cmd;
  logic [TAG_W-1:0] cur_tag;
  logic             push, start, done, first;

  assign req_ready = fill != FIL_W'(DEPTH);
  assign push      = req_valid && req_ready;
  assign done      = busy && timer == '0;
  assign first     = busy && timer == TMR_W'(LAT - 1);
  assign start     = fill != '0 && (!busy || done);

  assign reply_valid    = done && !cur_cmd[1];
  assign reply_excl     = reply_valid && cur_cmd[0];
  assign reply_tag      = cur_tag;
  assign wb_free_valid  = first && cur_cmd == CMD_WB;
  assign wb_free_tag    = cur_tag;
  assign swb_done_valid = done && cur_cmd == CMD_SWB;
  assign swb_done_tag   = cur_tag;

  always_ff @(posedge clk) begin
    if (push) begin
      q_tag[wr_ptr] <= req_tag;
      q_cmd[wr_ptr] <= req_cmd;
      q_ts[wr_ptr]  <= now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; fill <= '0; now <= '0;
      busy <= 1'b0; timer <= '0; cur_cmd <= '0; cur_tag <= '0;
      access_count <= '0; wait_total <= '0;
    end else begin
      now <= now + 1'b1;
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      fill <= fill + FIL_W'(push) - FIL_W'(start);
      if (start) begin
        rd_ptr       <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        busy         <= 1'b1;
        timer        <= TMR_W'(LAT - 1);
        cur_cmd      <= q_cmd[rd_ptr];
        cur_tag      <= q_tag[rd_ptr];
        access_count <= access_count + 1'b1;
        wait_total   <= wait_total + SUM_W'(TS_W'(now - q_ts[rd_ptr]));
      end else if (done) begin
        busy <= 1'b0;
      end else if (busy) begin
        timer <= timer - 1'b1;
      end
    end
  end

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && timer != '0 |=> busy && cur_tag == $past(cur_tag));
  // R3
  start_from_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fill) != '0);
  // R9
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fill != '0 |=> first);
  // R9
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && fill == '0 |=> !busy);
  // R3
  access_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(access_count) |-> access_count == CNT_W'($past(access_count) + 1'b1));
  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FIL_W'(DEPTH));
endmodule

// File: tb/bank_occupancy_ctrl_test.sv
module bank_occupancy_ctrl_test;
  localparam int LAT = 20;
  localparam int DEPTH = 8;
  localparam int TAG_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic req_ready, busy, reply_valid, reply_excl, wb_free_valid, swb_done_valid;
  logic [TAG_W-1:0] reply_tag, wb_free_tag, swb_done_tag;
  logic [31:0] access_count;
  logic [39:0] wait_total;

  bank_occupancy_ctrl #(.LAT(LAT), .DEPTH(DEPTH), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_tag(req_tag), .req_ready(req_ready), .busy(busy),
    .reply_valid(reply_valid), .reply_excl(reply_excl), .reply_tag(reply_tag),
    .wb_free_valid(wb_free_valid), .wb_free_tag(wb_free_tag),
    .swb_done_valid(swb_done_valid), .swb_done_tag(swb_done_tag),
    .access_count(access_count), .wait_total(wait_total));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit running = 1'b0;

  int q_tag[$], q_cmd[$], q_ts[$];
  bit m_busy = 0;
  int m_rem = 0, m_cmd = 0, m_tag = 0, cyc = 0;
  longint m_acc = 0, m_wait = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at model cycle %0d", rq, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (running) begin
    bit e_done, e_first, e_rep, e_wb, e_swb;
    e_done  = m_busy && m_rem == 1;
    e_first = m_busy && m_rem == LAT;
    e_rep   = e_done && m_cmd < 2;
    e_wb    = e_first && m_cmd == 2;
    e_swb   = e_done && m_cmd == 3;
    chk(busy == m_busy, "R5/R9 busy", busy, m_busy);
    chk(req_ready == (q_tag.size() < DEPTH), "R2 ready", req_ready, q_tag.size() < DEPTH);
    chk(reply_valid == e_rep, "R6 reply_valid", reply_valid, e_rep);
    if (e_rep) begin
      chk(reply_tag == TAG_W'(m_tag), "R3/R6 reply_tag", reply_tag, m_tag);
      chk(reply_excl == (m_cmd == 1), "R6 reply_excl", reply_excl, m_cmd == 1);
    end
    chk(wb_free_valid == e_wb, "R7 wb_free_valid", wb_free_valid, e_wb);
    if (e_wb) chk(wb_free_tag == TAG_W'(m_tag), "R7 wb_free_tag", wb_free_tag, m_tag);
    chk(swb_done_valid == e_swb, "R8 swb_done_valid", swb_done_valid, e_swb);
    if (e_swb) chk(swb_done_tag == TAG_W'(m_tag), "R8 swb_done_tag", swb_done_tag, m_tag);
    chk(access_count == 32'(m_acc), "R3 access_count", access_count, m_acc);
    chk(wait_total == 40'(m_wait), "R4 wait_total", wait_total, m_wait);
  end

  always @(posedge clk) if (running) begin
    bit acc;
    acc = req_valid && q_tag.size() < DEPTH;
    if (m_busy && m_rem > 1) m_rem--;
    else if (q_tag.size() > 0) begin
      m_busy = 1; m_rem = LAT;
      m_tag = q_tag.pop_front(); m_cmd = q_cmd.pop_front();
      m_acc++; m_wait += cyc - q_ts.pop_front();
    end else m_busy = 0;
    if (acc) begin
      q_tag.push_back(int'(req_tag)); q_cmd.push_back(int'(req_cmd)); q_ts.push_back(cyc);
    end
    cyc++;
  end

  int tag_ctr = 0;
  task automatic offer(input int cmd);
    @(negedge clk);
    #1;
    req_valid = 1'b1; req_cmd = 2'(cmd); req_tag = TAG_W'(tag_ctr); tag_ctr++;
    @(negedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    chk(reply_valid == 0 && wb_free_valid == 0 && swb_done_valid == 0, "R1 pulses",
        {reply_valid, wb_free_valid, swb_done_valid}, 0);
    chk(access_count == 0, "R1 access_count", access_count, 0);
    chk(wait_total == 0, "R1 wait_total", wait_total, 0);
    rst_n = 1'b1;
    running = 1'b1;
    // single commands on an idle bank (R4 wait of 1, R5..R8)
    for (int c = 0; c < 4; c++) begin offer(c); idle(LAT + 5); end
    // overfilling bursts: every cycle, more than DEPTH offers (R2, R3, R9)
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < 14; i++) begin
        @(negedge clk); #1;
        req_valid = 1'b1; req_cmd = 2'((i + b) % 4); req_tag = TAG_W'(tag_ctr); tag_ctr++;
      end
      @(negedge clk); #1; req_valid = 1'b0;
      idle(DEPTH * LAT / 2);
    end
    // random traffic with gaps
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk); #1;
      req_valid = ($urandom % 16) == 0;
      req_cmd = 2'($urandom % 4); req_tag = TAG_W'(tag_ctr); tag_ctr++;
    end
    @(negedge clk); #1; req_valid = 1'b0;
    idle((DEPTH + 2) * LAT);
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule